// File: doc/BRIEF.md
# Dual-Stage Conversion Result Counter

This block is the counting datapath of a dual-slope integrating converter. It has two counters. A wide coarse counter first times the signal integration window and then counts the fast reference ramp. A narrow fine counter first times the short bias interval and then counts the slow reference ramp. When the fine counter wraps, it carries into the coarse counter, so the two together form one result word. The external sequencer says which phase is active. The block answers with a done strobe when a timed phase has run its length.

When the sequencer enters its terminal phase, the counters and flags freeze. A processor then reads the result one byte at a time, using a 2-bit byte address that is qualified by a decoded read enable. A fourth address returns a status byte that holds the captured input polarity and an overrange flag. A read acknowledge releases the freeze, so the next conversion can start.

Top module: `dual_count_core`

## Requirements
- R1: Phase codes are 0 idle, 1 sync, 2 signal, 3 bias, 4 wait, 5 fast-ref, 6 slow-ref, 7 result-hold. In sync, both counters and the overrange flag clear on the next edge. In wait, both counters clear and the polarity input is captured.
- R2: In signal phase the coarse counter rises by one per clock until it equals the window length. The window length is SIG_NORM, or SIG_FAST when fast_i is high. sig_done is high exactly while phase is signal and the coarse count equals that length.
- R3: In bias phase the fine counter rises by one per clock until it equals BIAS_TICKS. bias_done is high exactly while phase is bias and the fine count equals BIAS_TICKS.
- R4: In fast-ref phase the coarse counter rises by one per clock.
- R5: In slow-ref phase the fine counter rises by one per clock. When the fine counter is all ones, it wraps to zero and the coarse counter rises by one on the same edge.
- R6: A coarse increment requested in either reference phase while the coarse counter is all ones leaves it at all ones and sets the overrange flag. Only sync clears the flag.
- R7: With rd_en high, rd_data is selected by rd_addr: 0 gives the fine count, 1 gives coarse bits 7:0, 2 gives coarse bits 15:8, and 3 gives status. In the status byte, bit 7 is polarity, bit 6 is overrange, and the other bits are zero. With rd_en low, rd_data is zero.
- R8: From the edge where phase 7 is seen until an edge with rd_ack high, the counters, the polarity and the overrange flag hold whatever phase is applied. rd_ack takes priority over phase 7, and updates resume on the edge after the acknowledge.
- R9: In idle phase all counter state holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_i | input | 3 | Sequencer phase code (see R1) |
| fast_i | input | 1 | Selects the short signal window |
| pol_i | input | 1 | Null-detector polarity, captured in wait |
| rd_en | input | 1 | Decoded read enable |
| rd_addr | input | 2 | Result byte select |
| rd_ack | input | 1 | Read acknowledge, releases the freeze |
| sig_done | output | 1 | Signal window complete |
| bias_done | output | 1 | Bias interval complete |
| rd_data | output | 8 | Selected result or status byte |

## Verification
A counter that steps wrongly or misses a carry shows up at rd_data in the very next cycle. The bench reads a rotating byte address on almost every clock while the phases run, so the wrong value is visible at once. A bad done compare shows as sig_done or bias_done moving one cycle early or late against the model. A freeze that leaks shows as a changed byte during the hold reads, before any acknowledge. A lost overrange or polarity shows in the status byte at the first read of address 3.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

    localparam int BYTE_W       = 8;
    localparam int RESULT_BYTES = 3;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SYNC  = 3'd1,
        PH_SIG   = 3'd2,
        PH_BIAS  = 3'd3,
        PH_WAIT  = 3'd4,
        PH_REF1  = 3'd5,
        PH_REF2  = 3'd6,
        PH_HOLD  = 3'd7
    } phase_e;

    typedef enum logic [1:0] {
        SEL_FINE     = 2'd0,
        SEL_COARSE_L = 2'd1,
        SEL_COARSE_H = 2'd2,
        SEL_STATUS   = 2'd3
    } rd_sel_e;

    typedef struct packed {
        logic clr_cnt;
        logic clr_flag;
        logic cap_pol;
        logic pri_time;
        logic sec_time;
        logic pri_acc;
        logic sec_acc;
        logic in_sig;
        logic in_bias;
    } cnt_ctl_t;

    function automatic cnt_ctl_t decode_phase(input phase_e ph, input logic hold);
        cnt_ctl_t c;
        c          = '0;
        c.in_sig   = (ph == PH_SIG);
        c.in_bias  = (ph == PH_BIAS);
        if (!hold) begin
            c.clr_cnt  = (ph == PH_SYNC) || (ph == PH_WAIT);
            c.clr_flag = (ph == PH_SYNC);
            c.cap_pol  = (ph == PH_WAIT);
            c.pri_time = (ph == PH_SIG);
            c.sec_time = (ph == PH_BIAS);
            c.pri_acc  = (ph == PH_REF1);
            c.sec_acc  = (ph == PH_REF2);
        end
        return c;
    endfunction

endpackage

// File: rtl/dcc_phase_ctrl.sv
module dcc_phase_ctrl
    import dcc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic [2:0] phase_i,
    input  logic     rd_ack,
    output cnt_ctl_t ctl,
    output logic     frozen
);
    phase_e ph;
    logic   hold;

    assign ph   = phase_e'(phase_i);
    assign hold = frozen || (ph == PH_HOLD);
    assign ctl  = decode_phase(ph, hold);

    always_ff @(posedge clk) begin
        if (rst) begin
            frozen <= 1'b0;
        end else if (rd_ack) begin
            frozen <= 1'b0;
        end else if (ph == PH_HOLD) begin
            frozen <= 1'b1;
        end
    end
endmodule

// File: rtl/dcc_counter_pair.sv
module dcc_counter_pair
    import dcc_pkg::*;
#(
    parameter int PRI_W      = 16,
    parameter int SEC_W      = 8,
    parameter int SIG_NORM   = 400,
    parameter int SIG_FAST   = 50,
    parameter int BIAS_TICKS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_ctl_t         ctl,
    input  logic             fast_i,
    input  logic             pol_i,
    output logic [PRI_W-1:0] pri_q,
    output logic [SEC_W-1:0] sec_q,
    output logic             ovr_q,
    output logic             pol_q,
    output logic             sig_done,
    output logic             bias_done
);
    localparam logic [PRI_W-1:0] PRI_MAX  = {PRI_W{1'b1}};
    localparam logic [SEC_W-1:0] SEC_MAX  = {SEC_W{1'b1}};
    localparam logic [PRI_W-1:0] WIN_NORM = PRI_W'(SIG_NORM);
    localparam logic [PRI_W-1:0] WIN_FAST = PRI_W'(SIG_FAST);
    localparam logic [SEC_W-1:0] BIAS_LEN = SEC_W'(BIAS_TICKS);

    logic [PRI_W-1:0] win_len;
    logic             sig_hit, bias_hit;
    logic             sec_wrap, pri_step;
    logic [PRI_W-1:0] pri_d;
    logic [SEC_W-1:0] sec_d;
    logic             ovr_d, pol_d;

    assign win_len   = fast_i ? WIN_FAST : WIN_NORM;
    assign sig_hit   = (pri_q == win_len);
    assign bias_hit  = (sec_q == BIAS_LEN);
    assign sig_done  = ctl.in_sig && sig_hit;
    assign bias_done = ctl.in_bias && bias_hit;

    assign sec_wrap  = ctl.sec_acc && (sec_q == SEC_MAX);
    assign pri_step  = ctl.pri_acc || sec_wrap;

    always_comb begin
        pri_d = pri_q;
        sec_d = sec_q;
        ovr_d = ovr_q;
        pol_d = pol_q;
        if (ctl.clr_cnt) begin
            pri_d = '0;
            sec_d = '0;
        end
        if (ctl.clr_flag) begin
            ovr_d = 1'b0;
        end
        if (ctl.cap_pol) begin
            pol_d = pol_i;
        end
        if (ctl.pri_time && !sig_hit) begin
            pri_d = pri_q + 1'b1;
        end
        if (ctl.sec_time && !bias_hit) begin
            sec_d = sec_q + 1'b1;
        end
        if (ctl.sec_acc) begin
            sec_d = sec_q + 1'b1;
        end
        if (pri_step) begin
            if (pri_q == PRI_MAX) begin
                ovr_d = 1'b1;
            end else begin
                pri_d = pri_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pri_q <= '0;
            sec_q <= '0;
            ovr_q <= 1'b0;
            pol_q <= 1'b0;
        end else begin
            pri_q <= pri_d;
            sec_q <= sec_d;
            ovr_q <= ovr_d;
            pol_q <= pol_d;
        end
    end
endmodule

// File: rtl/dcc_read_mux.sv
module dcc_read_mux
    import dcc_pkg::*;
#(
    parameter int PRI_W = 16,
    parameter int SEC_W = 8
) (
    input  logic              rd_en,
    input  logic [1:0]        rd_addr,
    input  logic [PRI_W-1:0]  pri_q,
    input  logic [SEC_W-1:0]  sec_q,
    input  logic              pol_q,
    input  logic              ovr_q,
    output logic [BYTE_W-1:0] rd_data
);
    localparam int RES_W = BYTE_W * RESULT_BYTES;

    logic [RES_W-1:0]  word;
    logic [BYTE_W-1:0] lanes [RESULT_BYTES+1];

    assign word = RES_W'({pri_q, sec_q});

    for (genvar i = 0; i < RESULT_BYTES; i++) begin : g_lane
        assign lanes[i] = word[i*BYTE_W +: BYTE_W];
    end
    assign lanes[RESULT_BYTES] = {pol_q, ovr_q, {(BYTE_W-2){1'b0}}};

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            unique case (rd_sel_e'(rd_addr))
                SEL_FINE:     rd_data = lanes[0];
                SEL_COARSE_L: rd_data = lanes[1];
                SEL_COARSE_H: rd_data = lanes[2];
                SEL_STATUS:   rd_data = lanes[RESULT_BYTES];
                default:      rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/dual_count_core.sv
module dual_count_core
    import dcc_pkg::*;
#(
    parameter int PRI_W      = 16,
    parameter int SEC_W      = 8,
    parameter int SIG_NORM   = 400,
    parameter int SIG_FAST   = 50,
    parameter int BIAS_TICKS = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] phase_i,
    input  logic       fast_i,
    input  logic       pol_i,
    input  logic       rd_en,
    input  logic [1:0] rd_addr,
    input  logic       rd_ack,
    output logic       sig_done,
    output logic       bias_done,
    output logic [7:0] rd_data
);
    cnt_ctl_t         ctl;
    logic             frozen;
    logic [PRI_W-1:0] pri_q;
    logic [SEC_W-1:0] sec_q;
    logic             ovr_q;
    logic             pol_q;

    dcc_phase_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .phase_i (phase_i),
        .rd_ack  (rd_ack),
        .ctl     (ctl),
        .frozen  (frozen)
    );

    dcc_counter_pair #(
        .PRI_W      (PRI_W),
        .SEC_W      (SEC_W),
        .SIG_NORM   (SIG_NORM),
        .SIG_FAST   (SIG_FAST),
        .BIAS_TICKS (BIAS_TICKS)
    ) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .fast_i    (fast_i),
        .pol_i     (pol_i),
        .pri_q     (pri_q),
        .sec_q     (sec_q),
        .ovr_q     (ovr_q),
        .pol_q     (pol_q),
        .sig_done  (sig_done),
        .bias_done (bias_done)
    );

    dcc_read_mux #(
        .PRI_W (PRI_W),
        .SEC_W (SEC_W)
    ) u_rd (
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .pri_q   (pri_q),
        .sec_q   (sec_q),
        .pol_q   (pol_q),
        .ovr_q   (ovr_q),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/dcc_checker.sv
module dcc_checker #(
    parameter int PRI_W = 16,
    parameter int SEC_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       phase_i,
    input logic             pol_i,
    input logic             rd_ack,
    input logic             rd_en,
    input logic [7:0]       rd_data,
    input logic             frozen,
    input logic [PRI_W-1:0] pri_q,
    input logic [SEC_W-1:0] sec_q,
    input logic             ovr_q,
    input logic             pol_q
);
    localparam logic [PRI_W-1:0] PMAX = {PRI_W{1'b1}};
    localparam logic [SEC_W-1:0] SMAX = {SEC_W{1'b1}};

    logic live;
    assign live = !frozen && (phase_i != 3'd7);

    AST_SYNC_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (live && phase_i == 3'd1) |=> (pri_q == '0 && sec_q == '0 && !ovr_q)); // R1

    AST_WAIT_POLARITY: assert property (@(posedge clk) disable iff (rst)
        (live && phase_i == 3'd4) |=> (pol_q == $past(pol_i))); // R1

    AST_FAST_REF_STEP: assert property (@(posedge clk) disable iff (rst)
        (live && phase_i == 3'd5 && pri_q != PMAX) |=> (pri_q == $past(pri_q) + 1'b1)); // R4

    AST_SLOW_REF_CARRY: assert property (@(posedge clk) disable iff (rst)
        (live && phase_i == 3'd6 && sec_q == SMAX && pri_q != PMAX)
        |=> (sec_q == '0 && pri_q == $past(pri_q) + 1'b1)); // R5

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (live && (phase_i == 3'd5 || phase_i == 3'd6) && pri_q == PMAX && (phase_i == 3'd5 || sec_q == SMAX))
        |=> (pri_q == PMAX && ovr_q)); // R6

    AST_READ_GATED: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (rd_data == 8'h00)); // R7

    AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        frozen |=> ($stable(pri_q) && $stable(sec_q) && $stable(ovr_q) && $stable(pol_q))); // R8

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (phase_i == 3'd0) |=> ($stable(pri_q) && $stable(sec_q))); // R9

    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
        rd_ack |=> !frozen); // R8
endmodule

bind dual_count_core dcc_checker #(
    .PRI_W (PRI_W),
    .SEC_W (SEC_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .phase_i (phase_i),
    .pol_i   (pol_i),
    .rd_ack  (rd_ack),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .frozen  (frozen),
    .pri_q   (pri_q),
    .sec_q   (sec_q),
    .ovr_q   (ovr_q),
    .pol_q   (pol_q)
);

// File: tb/dual_count_core_test.sv
module dual_count_core_test;
    localparam int NORM = 400;
    localparam int FAST = 50;
    localparam int BT   = 8;
    localparam int PMAX = 65535;
    localparam int SMAX = 255;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] phase_i = 3'd0;
    logic       fast_i = 1'b0;
    logic       pol_i = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] rd_addr = 2'd0;
    logic       rd_ack = 1'b0;
    logic       sig_done, bias_done;
    logic [7:0] rd_data;

    int checks = 0;
    int fails  = 0;
    int cyc_n  = 0;
    bit auto_rd = 1'b1;

    int mp = 0, ms = 0, movr = 0, mpol = 0, mfrz = 0;

    always #2.5 clk = ~clk;

    dual_count_core #(
        .SIG_NORM(NORM), .SIG_FAST(FAST), .BIAS_TICKS(BT)
    ) uut (
        .clk(clk), .rst(rst), .phase_i(phase_i), .fast_i(fast_i), .pol_i(pol_i),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_ack(rd_ack),
        .sig_done(sig_done), .bias_done(bias_done), .rd_data(rd_data)
    );

    // Behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        if (rst) begin
            mp <= 0; ms <= 0; movr <= 0; mpol <= 0; mfrz <= 0;
        end else begin
            if (mfrz == 0 && phase_i != 3'd7) begin
                case (phase_i)
                    3'd1: begin mp <= 0; ms <= 0; movr <= 0; end
                    3'd4: begin mp <= 0; ms <= 0; mpol <= int'(pol_i); end
                    3'd2: if (mp < (fast_i ? FAST : NORM)) mp <= mp + 1;
                    3'd3: if (ms < BT) ms <= ms + 1;
                    3'd5: if (mp == PMAX) movr <= 1; else mp <= mp + 1;
                    3'd6: begin
                        if (ms == SMAX) begin
                            ms <= 0;
                            if (mp == PMAX) movr <= 1; else mp <= mp + 1;
                        end else ms <= ms + 1;
                    end
                    default: ;
                endcase
            end
            if (rd_ack) mfrz <= 0;
            else if (phase_i == 3'd7) mfrz <= 1;
        end
    end

    function automatic string ptag(input logic [2:0] p);
        case (p)
            3'd1, 3'd4: return "R1";
            3'd2: return "R2";
            3'd3: return "R3";
            3'd5: return "R4";
            3'd6: return "R5";
            3'd7: return "R8";
            default: return "R9";
        endcase
    endfunction

    function automatic logic [7:0] exp_rd();
        if (!rd_en) return 8'h00;
        case (rd_addr)
            2'd0: return 8'(ms);
            2'd1: return 8'(mp);
            2'd2: return 8'(mp >> 8);
            default: return {mpol[0], movr[0], 6'b0};
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        string t;
        t = mfrz ? "R8" : ptag(phase_i);
        chk(phase_i == 3'd2 ? "R2" : t, "sig_done", int'(sig_done),
            int'(phase_i == 3'd2 && mp == (fast_i ? FAST : NORM)));
        chk(phase_i == 3'd3 ? "R3" : t, "bias_done", int'(bias_done),
            int'(phase_i == 3'd3 && ms == BT));
        chk($sformatf("R7 via %s", t), "rd_data", int'(rd_data), int'(exp_rd()));
    endtask

    task automatic run(input logic [2:0] p, input int n);
        for (int i = 0; i < n; i++) begin
            phase_i = p;
            if (auto_rd) begin
                rd_addr = 2'(cyc_n);
                rd_en   = (cyc_n % 5) != 0;
            end
            cyc_n++;
            @(posedge clk);
            @(negedge clk);
            compare_all();
        end
    endtask

    task automatic read_out();
        auto_rd = 1'b0;
        for (int a = 0; a < 4; a++) begin
            rd_en = 1'b1; rd_addr = 2'(a);
            run(3'd0, 1);
        end
        rd_en = 1'b0;
        run(3'd0, 1);
        auto_rd = 1'b1;
    endtask

    task automatic conversion(input logic fast, input logic pol, input int n1, input int n2);
        fast_i = fast;
        pol_i  = pol;
        run(3'd1, 1);
        run(3'd2, (fast ? FAST : NORM) + 3);
        run(3'd3, BT + 3);
        run(3'd4, 2);
        run(3'd5, n1);
        run(3'd6, n2);
        run(3'd7, 1);
        read_out();
        // phases applied while frozen must leave state untouched (R8)
        run(3'd1, 1);
        run(3'd5, 3);
        run(3'd4, 1);
        read_out();
        rd_ack = 1'b1;
        run(3'd0, 1);
        rd_ack = 1'b0;
        run(3'd0, 2);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare_all();                      // reset state, R9 tag
        rst = 1'b0;
        run(3'd0, 3);                       // R9 idle holds
        conversion(1'b0, 1'b1, 300, 700);   // R2 normal window, R5 carries
        conversion(1'b1, 1'b0, 5, 40);      // R2 fast window
        conversion(1'b1, 1'b1, 0, 1030);    // R5 several carries
        // R6: drive coarse counter to saturation
        fast_i = 1'b0;
        run(3'd1, 1);
        run(3'd5, PMAX + 4);
        run(3'd6, SMAX + 3);
        run(3'd7, 1);
        rd_en = 1'b1; rd_addr = 2'd3; auto_rd = 1'b0;
        run(3'd0, 1);
        chk("R6", "overrange status", int'(rd_data[6]), 1);
        rd_addr = 2'd2;
        run(3'd0, 1);
        chk("R6", "coarse high saturated", int'(rd_data), 8'hFF);
        rd_ack = 1'b1; run(3'd0, 1); rd_ack = 1'b0;
        run(3'd1, 1);
        rd_addr = 2'd3;
        run(3'd0, 1);
        chk("R6", "overrange cleared by sync", int'(rd_data[6]), 0);
        auto_rd = 1'b1;
        // R8: ack in same cycle as hold phase wins
        run(3'd5, 4);
        rd_ack = 1'b1; run(3'd7, 1); rd_ack = 1'b0;
        run(3'd5, 3);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule